// File: doc/BRIEF.md
# Sigma-Delta Loop Controller

This block is the digital half of a first-order sigma-delta converter whose integrator is an external resistor-capacitor node. Once per loop it takes a sample of the node's logic level through a feedback input. Straight after that sample it drives a bidirectional pad for one short slot, at the level opposite to the sample. For the rest of the loop it leaves the pad released, so the analog source alone charges the node. Because the pad is driven only briefly, a long input lead has little time to disturb the decision.

A loop is made of six slots of four clocks each, so one loop lasts 24 clocks. The block counts the high samples over a window of 2^N loops and issues that count as the conversion result with a single-cycle strobe. The user selects N. The result can pass through a four-deep moving average, or a control bit can route around the filter.

Top module: `sdadc_loop_ctrl`

## Requirements
- R1: While reset is asserted, and until the first sample has been taken, the drive enable is low and no result strobe is raised.
- R2: Counting rising clock edges from reset release as 1, 2, 3 and so on, the drive enable is high after edge c exactly when c >= 24 and c mod 24 is below 4. Each loop is therefore 24 clocks long and the pad is driven for one 4-clock slot directly after each sample. Outside that slot the pad is released.
- R3: While the drive enable is high, the drive level is the inverse of the most recent sample (feedback high gives drive low).
- R4: The feedback input passes through two flip-flops before it is sampled. Sample i is taken at edge 24(i+1) and holds the feedback level that was present just before edge 24(i+1)-2. A change applied after edge 24(i+1)-2 is not part of sample i.
- R5: The result is the number of high samples in a window of 2^N consecutive samples. N comes from the window setting clamped to the range 8 to 16: a value below 8 acts as 8 and a value above 16 acts as 16.
- R6: The result strobe is high for exactly one cycle per window. The first strobe after reset follows edge 24*2^N+1, and each following strobe comes 24*2^N clocks after the previous one. The count restarts from zero for each window.
- R7: With the filter enabled, the result is the floor of the sum of the current raw count and the three previous raw counts, divided by 4. Earlier counts that do not exist yet after reset are taken as zero.
- R8: With the filter bypassed, the result is the raw count of the window that just ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fb_i | input | 1 | Feedback level read from the external integrator node |
| win_log2_i | input | 5 | Window exponent N (clamped to 8..16) |
| filt_bypass_i | input | 1 | 1 routes the raw count to the result; 0 uses the four-deep average |
| drv_o | output | 1 | Drive level for the pad |
| drv_oe_o | output | 1 | Pad output enable; 0 means high impedance |
| result_o | output | 17 | Conversion result |
| result_valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench places feedback edges one clock on either side of the synchronizer boundary. A design with a short or long flop chain then counts a whole window wrongly, giving full scale where zero belongs, or the reverse. A periodic pattern that spans two windows exposes a counter that does not restart, or that is off by one sample, because the expected counts of 86 and 85 differ. The window clamp and a second window size catch exponent decoding errors, which show up as strobes at the wrong cycle. The filter warm-up sequence of 64, 128, 192 and 256 catches history that is not cleared, a wrong tap count, or a wrong divide shift.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;

  // Limit a requested window exponent to the supported span.
  function automatic int unsigned clamp_exp(int unsigned req, int unsigned lo, int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/sdadc_sync.sv
module sdadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q, chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = d_i;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sdadc_phase.sv
module sdadc_phase #(
  parameter int SLOT_CLKS = 4,
  parameter int NUM_SLOTS = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fb_sync_i,
  output logic samp_stb_o,
  output logic drv_o,
  output logic drv_oe_o
);

  localparam int LOOP_CLKS = SLOT_CLKS * NUM_SLOTS;
  localparam int PH_W      = $clog2(LOOP_CLKS);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            samp_q, samp_d;
  logic            primed_q, primed_d;
  logic            loop_end;
  logic            in_drive_slot;

  assign loop_end      = (ph_q == PH_W'(LOOP_CLKS - 1));
  assign in_drive_slot = (ph_q < PH_W'(SLOT_CLKS));

  always_comb begin
    ph_d     = loop_end ? '0 : ph_q + 1'b1;
    samp_d   = samp_q;
    primed_d = primed_q;
    if (loop_end) begin
      samp_d   = fb_sync_i;
      primed_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= '0;
      samp_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      samp_q   <= samp_d;
      primed_q <= primed_d;
    end
  end

  assign samp_stb_o = loop_end;
  assign drv_oe_o   = primed_q & in_drive_slot;
  assign drv_o      = drv_oe_o & ~samp_q;

endmodule

// File: rtl/sdadc_window.sv
module sdadc_window #(
  parameter int MIN_LOG2 = 8,
  parameter int MAX_LOG2 = 16,
  parameter int RES_W    = MAX_LOG2 + 1,
  parameter int LOG2_W   = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_stb_i,
  input  logic              samp_bit_i,
  input  logic [LOG2_W-1:0] win_log2_i,
  output logic [RES_W-1:0]  raw_o,
  output logic              raw_vld_o
);

  import sdadc_pkg::*;

  localparam int CNT_W = MAX_LOG2;

  logic [LOG2_W-1:0] n_eff;
  logic [LOG2_W-1:0] shamt;
  logic [CNT_W-1:0]  last_idx;
  logic [CNT_W-1:0]  loop_cnt_q, loop_cnt_d;
  logic [RES_W-1:0]  hits_q, hits_d;
  logic [RES_W-1:0]  raw_q, raw_d;
  logic              raw_en;
  logic              vld_q, vld_d;
  logic              win_done;

  always_comb begin
    n_eff    = LOG2_W'(clamp_exp(int'(win_log2_i), MIN_LOG2, MAX_LOG2));
    shamt    = LOG2_W'(MAX_LOG2) - n_eff;
    last_idx = {CNT_W{1'b1}} >> shamt;
  end

  assign win_done = samp_stb_i && (loop_cnt_q >= last_idx);

  always_comb begin
    loop_cnt_d = loop_cnt_q;
    hits_d     = hits_q;
    raw_d      = hits_q + RES_W'(samp_bit_i);
    raw_en     = 1'b0;
    vld_d      = 1'b0;
    if (win_done) begin
      loop_cnt_d = '0;
      hits_d     = '0;
      raw_en     = 1'b1;
      vld_d      = 1'b1;
    end else if (samp_stb_i) begin
      loop_cnt_d = loop_cnt_q + 1'b1;
      hits_d     = hits_q + RES_W'(samp_bit_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loop_cnt_q <= '0;
      hits_q     <= '0;
      raw_q      <= '0;
      vld_q      <= 1'b0;
    end else begin
      loop_cnt_q <= loop_cnt_d;
      hits_q     <= hits_d;
      vld_q      <= vld_d;
      if (raw_en) raw_q <= raw_d;
    end
  end

  assign raw_o     = raw_q;
  assign raw_vld_o = vld_q;

endmodule

// File: rtl/sdadc_mavg.sv
module sdadc_mavg #(
  parameter int W          = 17,
  parameter int DEPTH_LOG2 = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bypass_i,
  input  logic [W-1:0] in_i,
  input  logic         in_vld_i,
  output logic [W-1:0] out_o,
  output logic         out_vld_o
);

  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int SUM_W = W + DEPTH_LOG2;

  logic [W-1:0]     hist_q [DEPTH-1];
  logic [W-1:0]     hist_d [DEPTH-1];
  logic [SUM_W-1:0] sum;
  logic [W-1:0]     out_q, out_d;
  logic             vld_q;

  assign hist_d[0] = in_i;
  generate
    for (genvar k = 1; k < DEPTH - 1; k++) begin : g_shift
      assign hist_d[k] = hist_q[k-1];
    end
  endgenerate

  always_comb begin
    sum = SUM_W'(in_i);
    for (int k = 0; k < DEPTH - 1; k++) sum = sum + SUM_W'(hist_q[k]);
    out_d = bypass_i ? in_i : sum[SUM_W-1:DEPTH_LOG2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH - 1; k++) hist_q[k] <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_vld_i;
      if (in_vld_i) begin
        for (int k = 0; k < DEPTH - 1; k++) hist_q[k] <= hist_d[k];
        out_q <= out_d;
      end
    end
  end

  assign out_o     = out_q;
  assign out_vld_o = vld_q;

endmodule

// File: rtl/sdadc_loop_ctrl.sv
module sdadc_loop_ctrl #(
  parameter int SLOT_CLKS   = 4,
  parameter int NUM_SLOTS   = 6,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOG2    = 8,
  parameter int MAX_LOG2    = 16,
  parameter int AVG_LOG2    = 2,
  localparam int RES_W      = MAX_LOG2 + 1,
  localparam int LOG2_W     = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fb_i,
  input  logic [LOG2_W-1:0] win_log2_i,
  input  logic              filt_bypass_i,
  output logic              drv_o,
  output logic              drv_oe_o,
  output logic [RES_W-1:0]  result_o,
  output logic              result_valid_o
);

  logic             fb_sync;
  logic             samp_stb;
  logic [RES_W-1:0] raw;
  logic             raw_vld;

  sdadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (fb_i),
    .q_o   (fb_sync)
  );

  sdadc_phase #(.SLOT_CLKS(SLOT_CLKS), .NUM_SLOTS(NUM_SLOTS)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fb_sync_i (fb_sync),
    .samp_stb_o(samp_stb),
    .drv_o     (drv_o),
    .drv_oe_o  (drv_oe_o)
  );

  sdadc_window #(
    .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2), .RES_W(RES_W), .LOG2_W(LOG2_W)
  ) u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .samp_stb_i(samp_stb),
    .samp_bit_i(fb_sync),
    .win_log2_i(win_log2_i),
    .raw_o     (raw),
    .raw_vld_o (raw_vld)
  );

  sdadc_mavg #(.W(RES_W), .DEPTH_LOG2(AVG_LOG2)) u_mavg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (filt_bypass_i),
    .in_i     (raw),
    .in_vld_i (raw_vld),
    .out_o    (result_o),
    .out_vld_o(result_valid_o)
  );

endmodule

// File: rtl/sdadc_loop_ctrl_chk.sv
module sdadc_loop_ctrl_chk #(
  parameter int SLOT_CLKS = 4,
  parameter int NUM_SLOTS = 6,
  parameter int MAX_LOG2  = 16,
  parameter int RES_W     = MAX_LOG2 + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             drv_o,
  input logic             drv_oe_o,
  input logic [RES_W-1:0] result_o,
  input logic             result_valid_o
);

  localparam int LOOP_CLKS = SLOT_CLKS * NUM_SLOTS;
  localparam int RUN_W     = $clog2(LOOP_CLKS + 2) + 1;

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      run_q <= drv_oe_o ? run_q + 1'b1 : '0;
      if (drv_oe_o && run_q == '0) begin
        gap_q  <= RUN_W'(1);
        seen_q <= 1'b1;
      end else if (gap_q != {RUN_W{1'b1}}) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  assert_slot_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drv_oe_o) |-> run_q == RUN_W'(SLOT_CLKS));

  assert_loop_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(drv_oe_o) && seen_q) |-> gap_q == RUN_W'(LOOP_CLKS));

  assert_drive_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_oe_o && $past(drv_oe_o)) |-> $stable(drv_o));

  assert_single_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);

  assert_result_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> result_o <= (RES_W'(1) << MAX_LOG2));

endmodule

bind sdadc_loop_ctrl sdadc_loop_ctrl_chk #(
  .SLOT_CLKS(SLOT_CLKS), .NUM_SLOTS(NUM_SLOTS), .MAX_LOG2(MAX_LOG2), .RES_W(RES_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .drv_o         (drv_o),
  .drv_oe_o      (drv_oe_o),
  .result_o      (result_o),
  .result_valid_o(result_valid_o)
);

// File: tb/tb_sdadc_loop_ctrl.sv
module tb_sdadc_loop_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int LOOP       = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fb;
  logic [4:0]  win;
  logic        byp;
  logic        drv, drv_oe;
  logic [16:0] res;
  logic        res_vld;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc;
  int fb_lvl;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  sdadc_loop_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .fb_i(fb), .win_log2_i(win),
    .filt_bypass_i(byp), .drv_o(drv), .drv_oe_o(drv_oe),
    .result_o(res), .result_valid_o(res_vld)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // modes: 0 constant, 1 every third loop high, 2 early pulse, 3 late pulse
  function automatic logic fb_val(int mode, int c);
    case (mode)
      0:       return fb_lvl[0];
      1:       return ((c / LOOP) % 3) == 0;
      2:       return (c % LOOP) == 21 || (c % LOOP) == 22;
      default: return (c % LOOP) == 22 || (c % LOOP) == 23;
    endcase
  endfunction

  task automatic apply_reset(int mode, int w, bit b);
    rst_n = 1'b0;
    win   = w[4:0];
    byp   = b;
    fb    = fb_val(mode, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive_fb(int mode, int ncyc);
    repeat (ncyc) begin
      @(negedge clk);
      fb = fb_val(mode, cyc);
    end
  endtask

  task automatic wait_result(output int v, output int at);
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!res_vld && t < 20000);
    v  = int'(res);
    at = res_vld ? cyc : -1;
  endtask

  task automatic test_reset_and_slot(int lvl);
    int pre_bad = 0, slot_bad = 0, lvl_bad = 0;
    fb_lvl = lvl;
    rst_n = 1'b0; win = 5'd8; byp = 1'b1; fb = lvl[0];
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 oe in reset", int'(drv_oe), 0);
    check("R1 valid in reset", int'(res_vld), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 100; k++) begin
      bit exp_oe;
      @(negedge clk);
      exp_oe = (cyc >= LOOP) && ((cyc % LOOP) < 4);
      if (cyc < LOOP && (drv_oe || res_vld)) pre_bad++;
      if (drv_oe !== exp_oe) slot_bad++;
      if (drv_oe && drv !== ~lvl[0]) lvl_bad++;
    end
    check("R1 quiet before first sample", pre_bad, 0);
    check("R2 drive slot timing", slot_bad, 0);
    check("R3 drive opposite to sample", lvl_bad, 0);
  endtask

  task automatic test_constant(int lvl, int w, int exp_cnt, string req);
    int v, at, v2, at2;
    fb_lvl = lvl;
    apply_reset(0, w, 1'b1);
    wait_result(v, at);
    check({req, " first count"}, v, exp_cnt);
    check("R6 first strobe cycle", at, LOOP * (1 << w) + 1);
    @(negedge clk);
    check("R6 strobe one cycle", int'(res_vld), 0);
    if (w == 8) begin
      wait_result(v2, at2);
      check("R6 restart count", v2, exp_cnt);
      check("R6 strobe spacing", at2 - at, LOOP * 256);
    end
  endtask

  task automatic test_clamp;
    int v, at;
    fb_lvl = 1;
    apply_reset(0, 3, 1'b1);
    wait_result(v, at);
    check("R5 clamp low count", v, 256);
    check("R5 clamp low strobe cycle", at, LOOP * 256 + 1);
  endtask

  task automatic test_pattern;
    int v0, a0, v1, a1, e0 = 0, e1 = 0;
    for (int i = 0; i < 256; i++) if (i % 3 == 0) e0++;
    for (int i = 256; i < 512; i++) if (i % 3 == 0) e1++;
    apply_reset(1, 8, 1'b1);
    fork
      drive_fb(1, 2 * LOOP * 256 + 4);
      begin
        wait_result(v0, a0);
        wait_result(v1, a1);
      end
    join
    check("R5 pattern window 0", v0, e0);
    check("R6 pattern window 1 restart", v1, e1);
  endtask

  task automatic test_sync(int mode, int exp_cnt);
    int v, at;
    apply_reset(mode, 8, 1'b1);
    fork
      drive_fb(mode, LOOP * 256 + 4);
      wait_result(v, at);
    join
    check(mode == 2 ? "R4 pulse before boundary" : "R4 pulse after boundary", v, exp_cnt);
  endtask

  task automatic test_filter;
    int v, at;
    int exp_seq[5] = '{64, 128, 192, 256, 256};
    fb_lvl = 1;
    apply_reset(0, 8, 1'b0);
    for (int k = 0; k < 5; k++) begin
      wait_result(v, at);
      check("R7 moving average", v, exp_seq[k]);
    end
    byp = 1'b1;
    wait_result(v, at);
    check("R8 bypass raw", v, 256);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    test_reset_and_slot(1);
    test_reset_and_slot(0);
    test_constant(1, 8, 256, "R5 all high");
    test_constant(0, 8, 0, "R5 all low");
    test_constant(1, 9, 512, "R5 window 2^9");
    test_clamp();
    test_pattern();
    test_sync(2, 256);
    test_sync(3, 0);
    test_filter();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule